// File: doc/BRIEF.md
# Flash Protection Pulse Sequencer

This block sits on the host side of a parallel byte-wide flash device. It runs the closed-loop routine that locks or unlocks the whole device against writes. One request from the host sets the pins to the levels the chosen operation needs and applies a timed write strobe. The block then reads back a status byte from a sector address. It repeats the strobe until that byte shows the wanted state or a per-operation pulse budget is spent. On success it drops the elevated level on address line 9 and writes the device's reset command.

Pulse length is counted in ticks of an external timebase, so the host sets the real-time width by choosing the tick rate. Some boards cannot supply the elevated level. For those, a low-voltage variant writes an unlock command before every pulse and drives no elevated level. Its pulse is a single-cycle start strobe, and the fixed wait is replaced by polling the device's toggling status bit until it settles. The outcome is reported on two exclusive flags. Each flag stays set until the next request.

Top module: `chip_lock_seq`

## Requirements
- R1: Reset state: ceN, oeN and weN are high; hvOe, hvA9, dqOe, done and fail are low.
- R2: In a lock run with elevated levels, each pulse holds weN low for exactly PROT_WIDTH ticks. During the pulse, ceN is low, hvOe and hvA9 are high, address bit 9 is 1 and address bit 6 is 0.
- R3: In an unlock run, each pulse holds weN low for exactly UNPROT_WIDTH ticks with address bit 6 set to 1.
- R4: After every pulse the block makes one verify read. During it, oeN is low and hvOe is off. The address is SECTOR_ADDR with bits 1 and 9 set. The pass byte is 8'h01 for lock and 8'h00 for unlock.
- R5: The pulse count restarts at 1 on every request. Pulses repeat until a verify read returns the pass byte.
- R6: If verification keeps failing, exactly PROT_MAX (lock) or UNPROT_MAX (unlock) pulses are applied. fail then rises, and no reset command is written.
- R7: On a passing verify, hvA9 drops and one write of 8'hF0 is made with hvA9 low. done rises after that write.
- R8: done and fail are never high together. Each stays high until the next start request, which clears it.
- R9: In low-voltage mode, one write of UNLOCK_DATA to UNLOCK_ADDR precedes every pulse. The pulse is one clock wide and hvOe and hvA9 stay low.
- R10: In low-voltage mode, after each pulse the block reads repeatedly until two consecutive reads agree on data bit 6. It then makes the verify read.
- R11: Pulse width counts cycles with tick high, not clock cycles.
- R12: weN is never low while oeN is low, and weN low implies ceN low. hvOe high implies oeN high and hvA9 high. dqOe high implies oeN high.
- R13: The mode and low-voltage inputs are sampled only when a request is accepted. Changes during a run do not alter its pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted when idle or finished |
| modeUnprot | input | 1 | 0 = lock, 1 = unlock |
| lowVolt | input | 1 | 1 = no elevated supply: unlock write and toggle polling |
| tick | input | 1 | Timebase strobe for pulse width |
| rdData | input | 8 | Data byte read from the device |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| weN | output | 1 | Write enable, active low |
| hvOe | output | 1 | Select elevated level on the output-enable pin |
| hvA9 | output | 1 | Select elevated level on address pin 9 |
| addr | output | ADDR_W | Device address |
| wrData | output | 8 | Data for write cycles |
| dqOe | output | 1 | Drive wrData onto the data bus |
| done | output | 1 | Operation succeeded; held until next start |
| fail | output | 1 | Pulse budget exhausted; held until next start |

## Verification
The hardest case to reach is the end of the unlock budget. It takes a thousand unsuccessful pulse-and-verify rounds, so the bench overrides the unlock width to a few ticks and gives its behavioural device model a pass threshold it never reaches. The model also makes data bit 6 toggle on each output-enable release for a chosen number of reads after a low-voltage start strobe. This lets the bench predict the exact number of polling reads.

// File: rtl/chip_lock_pkg.sv
package chip_lock_pkg;

  localparam int A1_BIT = 1;
  localparam int A6_BIT = 6;
  localparam int A9_BIT = 9;
  localparam int TOGGLE_BIT = 6;
  localparam logic [7:0] RESET_CMD = 8'hF0;
  localparam logic [7:0] LOCK_PASS = 8'h01;
  localparam logic [7:0] UNLOCK_PASS = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_UNLK_WR, S_UNLK_REL, S_SETUP, S_PULSE, S_PULSE_REL,
    S_POLL_RD, S_POLL_CHK, S_VFY_RD, S_VFY_CHK, S_RST_WR, S_RST_REL,
    S_PASS, S_FAIL
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armRun;
    logic incPulse;
    logic clrTick;
    logic clrPoll;
    logic capPoll;
    logic capVerify;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic widthDone;
    logic atLimit;
    logic verifyOk;
    logic toggleSettled;
    logic lowVolt;
    logic unprot;
  } dpStat_t;

endpackage

// File: rtl/chip_lock_dp.sv
module chip_lock_dp
  import chip_lock_pkg::*;
#(
  parameter int PROT_WIDTH   = 10,
  parameter int UNPROT_WIDTH = 12000,
  parameter int PROT_MAX     = 32,
  parameter int UNPROT_MAX   = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeIn,
  input  logic       lowVoltIn,
  input  logic       tick,
  input  logic [7:0] rdData,
  input  dpCmd_t     cmd,
  output dpStat_t    stat
);

  localparam int WIDTH_MAX = (PROT_WIDTH > UNPROT_WIDTH) ? PROT_WIDTH : UNPROT_WIDTH;
  localparam int COUNT_MAX = (PROT_MAX > UNPROT_MAX) ? PROT_MAX : UNPROT_MAX;
  localparam int TICK_W    = $clog2(WIDTH_MAX + 1);
  localparam int CNT_W     = $clog2(COUNT_MAX + 1);

  logic              unprotQ;
  logic              lowVoltQ;
  logic [CNT_W-1:0]  pulseCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [7:0]        verifyByte;
  logic              pollPrev;
  logic              pollCur;
  logic [1:0]        pollSeen;
  logic [TICK_W-1:0] widthLast;
  logic [CNT_W-1:0]  pulseLimit;

  assign widthLast  = unprotQ ? TICK_W'(UNPROT_WIDTH - 1) : TICK_W'(PROT_WIDTH - 1);
  assign pulseLimit = unprotQ ? CNT_W'(UNPROT_MAX) : CNT_W'(PROT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unprotQ  <= 1'b0;
      lowVoltQ <= 1'b0;
      pulseCnt <= '0;
    end else if (cmd.armRun) begin
      unprotQ  <= modeIn;
      lowVoltQ <= lowVoltIn;
      pulseCnt <= CNT_W'(1);
    end else if (cmd.incPulse) begin
      pulseCnt <= pulseCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else if (cmd.clrTick) tickCnt <= '0;
    else if (tick) tickCnt <= tickCnt + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) verifyByte <= 8'hFF;
    else if (cmd.capVerify) verifyByte <= rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollPrev <= 1'b0;
      pollCur  <= 1'b0;
      pollSeen <= 2'd0;
    end else if (cmd.clrPoll) begin
      pollSeen <= 2'd0;
    end else if (cmd.capPoll) begin
      pollPrev <= pollCur;
      pollCur  <= rdData[TOGGLE_BIT];
      if (pollSeen != 2'd2) pollSeen <= pollSeen + 2'd1;
    end
  end

  always_comb begin
    stat.widthDone     = tick && (tickCnt == widthLast);
    stat.atLimit       = (pulseCnt == pulseLimit);
    stat.verifyOk      = (verifyByte == (unprotQ ? UNLOCK_PASS : LOCK_PASS));
    stat.toggleSettled = (pollSeen == 2'd2) && (pollPrev == pollCur);
    stat.lowVolt       = lowVoltQ;
    stat.unprot        = unprotQ;
  end

endmodule

// File: rtl/chip_lock_ctrl.sv
module chip_lock_ctrl
  import chip_lock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] SECTOR_ADDR = 17'h1E000,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 17'h00555,
  parameter logic [7:0] UNLOCK_DATA = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              lowVoltIn,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic              ceN,
  output logic              oeN,
  output logic              weN,
  output logic              hvOe,
  output logic              hvA9,
  output logic              dqOe,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wrData,
  output logic              done,
  output logic              fail
);

  localparam logic [ADDR_W-1:0] A1_MASK = ADDR_W'(1) << A1_BIT;
  localparam logic [ADDR_W-1:0] A6_MASK = ADDR_W'(1) << A6_BIT;
  localparam logic [ADDR_W-1:0] A9_MASK = ADDR_W'(1) << A9_BIT;
  localparam logic [ADDR_W-1:0] VFY_ADDR = SECTOR_ADDR | A1_MASK | A9_MASK;

  seqState_e state, nextState;
  logic [ADDR_W-1:0] pulseAddr;
  logic highV;

  assign pulseAddr = A9_MASK | (stat.unprot ? A6_MASK : '0);
  assign highV     = !stat.lowVolt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd = '0;
    unique case (state)
      S_IDLE, S_PASS, S_FAIL: begin
        if (start) begin
          cmd.armRun = 1'b1;
          nextState = lowVoltIn ? S_UNLK_WR : S_SETUP;
        end
      end
      S_UNLK_WR:  nextState = S_UNLK_REL;
      S_UNLK_REL: nextState = S_SETUP;
      S_SETUP: begin
        cmd.clrTick = 1'b1;
        nextState = S_PULSE;
      end
      S_PULSE: begin
        if (stat.lowVolt || stat.widthDone) nextState = S_PULSE_REL;
      end
      S_PULSE_REL: begin
        if (stat.lowVolt) begin
          cmd.clrPoll = 1'b1;
          nextState = S_POLL_RD;
        end else begin
          nextState = S_VFY_RD;
        end
      end
      S_POLL_RD: begin
        cmd.capPoll = 1'b1;
        nextState = S_POLL_CHK;
      end
      S_POLL_CHK: nextState = stat.toggleSettled ? S_VFY_RD : S_POLL_RD;
      S_VFY_RD: begin
        cmd.capVerify = 1'b1;
        nextState = S_VFY_CHK;
      end
      S_VFY_CHK: begin
        if (stat.verifyOk) begin
          nextState = S_RST_WR;
        end else if (stat.atLimit) begin
          nextState = S_FAIL;
        end else begin
          cmd.incPulse = 1'b1;
          nextState = stat.lowVolt ? S_UNLK_WR : S_SETUP;
        end
      end
      S_RST_WR:  nextState = S_RST_REL;
      S_RST_REL: nextState = S_PASS;
      default:   nextState = S_IDLE;
    endcase
  end

  // pin levels decoded from the current state
  always_comb begin
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    hvOe = 1'b0; hvA9 = 1'b0; dqOe = 1'b0;
    addr = '0; wrData = 8'h00;
    unique case (state)
      S_UNLK_WR, S_UNLK_REL: begin
        ceN = 1'b0; dqOe = 1'b1;
        weN = (state != S_UNLK_WR);
        addr = UNLOCK_ADDR; wrData = UNLOCK_DATA;
      end
      S_SETUP, S_PULSE, S_PULSE_REL: begin
        ceN = 1'b0;
        weN = (state != S_PULSE);
        hvOe = highV; hvA9 = highV;
        addr = pulseAddr;
      end
      S_POLL_RD, S_POLL_CHK, S_VFY_RD, S_VFY_CHK: begin
        ceN = 1'b0;
        oeN = !(state == S_POLL_RD || state == S_VFY_RD);
        hvA9 = highV;
        addr = VFY_ADDR;
      end
      S_RST_WR, S_RST_REL: begin
        ceN = 1'b0; dqOe = 1'b1;
        weN = (state != S_RST_WR);
        wrData = RESET_CMD;
      end
      default: ;
    endcase
  end

  assign done = (state == S_PASS);
  assign fail = (state == S_FAIL);

endmodule

// File: rtl/chip_lock_seq.sv
module chip_lock_seq
  import chip_lock_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PROT_WIDTH   = 10,
  parameter int UNPROT_WIDTH = 12000,
  parameter int PROT_MAX     = 32,
  parameter int UNPROT_MAX   = 1000,
  parameter logic [ADDR_W-1:0] SECTOR_ADDR = 17'h1E000,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 17'h00555,
  parameter logic [7:0] UNLOCK_DATA = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeUnprot,
  input  logic              lowVolt,
  input  logic              tick,
  input  logic [7:0]        rdData,
  output logic              ceN,
  output logic              oeN,
  output logic              weN,
  output logic              hvOe,
  output logic              hvA9,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wrData,
  output logic              dqOe,
  output logic              done,
  output logic              fail
);

  dpCmd_t  cmd;
  dpStat_t stat;

  chip_lock_ctrl #(
    .ADDR_W(ADDR_W), .SECTOR_ADDR(SECTOR_ADDR),
    .UNLOCK_ADDR(UNLOCK_ADDR), .UNLOCK_DATA(UNLOCK_DATA)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .lowVoltIn(lowVolt),
    .stat(stat), .cmd(cmd),
    .ceN(ceN), .oeN(oeN), .weN(weN), .hvOe(hvOe), .hvA9(hvA9),
    .dqOe(dqOe), .addr(addr), .wrData(wrData), .done(done), .fail(fail)
  );

  chip_lock_dp #(
    .PROT_WIDTH(PROT_WIDTH), .UNPROT_WIDTH(UNPROT_WIDTH),
    .PROT_MAX(PROT_MAX), .UNPROT_MAX(UNPROT_MAX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .modeIn(modeUnprot), .lowVoltIn(lowVolt),
    .tick(tick), .rdData(rdData), .cmd(cmd), .stat(stat)
  );

endmodule

// File: rtl/chip_lock_chk.sv
module chip_lock_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic ceN,
  input logic oeN,
  input logic weN,
  input logic hvOe,
  input logic hvA9,
  input logic dqOe,
  input logic done,
  input logic fail
);

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && fail));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (done && !start) |=> done);
  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (fail && !start) |=> fail);
  // R12
  we_oe_chk: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !oeN));
  // R12
  we_ce_chk: assert property (@(posedge clk) disable iff (!rstN) !weN |-> !ceN);
  // R12
  hv_oe_chk: assert property (@(posedge clk) disable iff (!rstN) hvOe |-> (oeN && hvA9));
  // R12
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rstN) dqOe |-> oeN);
  // R7
  done_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!hvA9 && $past(weN, 1) && !$past(weN, 2)));

endmodule

bind chip_lock_seq chip_lock_chk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .ceN(ceN), .oeN(oeN), .weN(weN),
  .hvOe(hvOe), .hvA9(hvA9), .dqOe(dqOe), .done(done), .fail(fail)
);

// File: tb/chip_lock_seq_test.sv
module chip_lock_seq_test;

  localparam logic [16:0] SECT = 17'h1E000;
  localparam logic [16:0] VFY = 17'h1E202;
  localparam logic [7:0] UNLK = 8'h60;
  localparam int UNPROT_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, modeUnprot = 1'b0, lowVolt = 1'b0, tick = 1'b0;
  logic [7:0] rdData;
  logic ceN, oeN, weN, hvOe, hvA9, dqOe, done, fail;
  logic [16:0] addr;
  logic [7:0] wrData;

  int vectors = 0, miscompares = 0;
  int need = 1, busyReads = 0, tickDiv = 1, tickPh = 0;
  int clrReq = 0, clrSeen = 0;
  int pulses, a6Ones, a6Zeros, pulseHv, minW, maxW, weLow;
  int unlockWrites, resetWrites, resetHv, reads, vfyAddrBad, vfyHvBad, pollBusy;
  logic toggleBit, lastA6, prevWe, prevOe;

  always #5 clk = ~clk;

  chip_lock_seq #(.UNPROT_WIDTH(UNPROT_W), .SECTOR_ADDR(SECT), .UNLOCK_DATA(UNLK)) uut (
    .clk(clk), .rstN(rstN), .start(start), .modeUnprot(modeUnprot),
    .lowVolt(lowVolt), .tick(tick), .rdData(rdData),
    .ceN(ceN), .oeN(oeN), .weN(weN), .hvOe(hvOe), .hvA9(hvA9),
    .addr(addr), .wrData(wrData), .dqOe(dqOe), .done(done), .fail(fail)
  );

  // behavioural device: passes once "need" pulses have been seen
  always_comb begin
    logic [7:0] b;
    if (pulses >= need) b = lastA6 ? 8'h00 : 8'h01;
    else b = lastA6 ? 8'h01 : 8'h00;
    if (pollBusy > 0) b[6] = toggleBit;
    rdData = b;
  end

  always @(negedge clk) begin
    tickPh = (tickPh + 1) % tickDiv;
    tick = (tickPh == 0);
  end

  always @(negedge clk) begin
    if (clrReq != clrSeen) begin
      clrSeen = clrReq;
      pulses = 0; a6Ones = 0; a6Zeros = 0; pulseHv = 0; minW = 1000000; maxW = 0;
      unlockWrites = 0; resetWrites = 0; resetHv = 0; reads = 0;
      vfyAddrBad = 0; vfyHvBad = 0; pollBusy = 0; lastA6 = 1'b0; toggleBit = 1'b0;
    end
    if (!weN) weLow++;
    if (!weN && prevWe) begin
      if (addr[9] && !dqOe) begin
        pulses++;
        lastA6 = addr[6];
        if (addr[6]) a6Ones++; else a6Zeros++;
        if (hvA9 && hvOe && !ceN) pulseHv++;
        if (!hvA9) begin pollBusy = busyReads; toggleBit = 1'b1; end
      end
      if (dqOe && wrData == 8'hF0) begin resetWrites++; if (hvA9) resetHv++; end
      if (dqOe && wrData == UNLK && addr == 17'h00555) unlockWrites++;
    end
    if (weN && !prevWe) begin
      if (addr[9] && !dqOe) begin
        if (weLow < minW) minW = weLow;
        if (weLow > maxW) maxW = weLow;
      end
      weLow = 0;
    end
    if (!oeN) begin
      reads++;
      if (addr != VFY) vfyAddrBad++;
      if (hvOe) vfyHvBad++;
    end
    if (oeN && !prevOe && pollBusy > 0) begin
      pollBusy--;
      toggleBit = ~toggleBit;
    end
    prevWe = weN;
    prevOe = oeN;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // run one request; flip mode inputs after flipAt cycles when flipAt > 0
  task automatic runSeq(input bit m, input bit lv, input int nd, input int busy,
                        input int flipAt);
    need = nd; busyReads = busy;
    clrReq++;
    @(negedge clk); @(negedge clk);
    modeUnprot = m; lowVolt = lv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60000; i++) begin
      if (done || fail) break;
      if (flipAt > 0 && i == flipAt) begin modeUnprot = ~m; lowVolt = ~lv; end
      @(negedge clk);
    end
    chk(done || fail, "watchdog", 0, 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(ceN && oeN && weN, "R1 strobes", {ceN, oeN, weN}, 7);
    chk(!hvOe && !hvA9 && !dqOe, "R1 drives", {hvOe, hvA9, dqOe}, 0);
    chk(!done && !fail, "R1 flags", {done, fail}, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testLockPass();
    runSeq(1'b0, 1'b0, 3, 0, 0);
    chk(done && !fail, "R7 done", {done, fail}, 2);
    chk(pulses == 3, "R5 pulse count", pulses, 3);
    chk(minW == 10 && maxW == 10, "R2 width", maxW, 10);
    chk(a6Ones == 0 && pulseHv == 3, "R2 levels", pulseHv, 3);
    chk(reads == 3 && vfyAddrBad == 0, "R4 verify reads", reads, 3);
    chk(vfyHvBad == 0, "R4 oe level", vfyHvBad, 0);
    chk(resetWrites == 1 && resetHv == 0, "R7 reset write", resetWrites, 1);
    chk(unlockWrites == 0, "R9 no unlock", unlockWrites, 0);
  endtask

  task automatic testUnlockPass();
    runSeq(1'b1, 1'b0, 2, 0, 0);
    chk(done, "R3 done", done, 1);
    chk(pulses == 2, "R5 unlock count", pulses, 2);
    chk(minW == UNPROT_W && maxW == UNPROT_W, "R3 width", maxW, UNPROT_W);
    chk(a6Zeros == 0 && a6Ones == 2, "R3 a6", a6Ones, 2);
  endtask

  task automatic testLockLimit();
    runSeq(1'b0, 1'b0, 1000000, 0, 0);
    chk(fail && !done, "R6 lock fail", {done, fail}, 1);
    chk(pulses == 32, "R6 lock budget", pulses, 32);
    chk(resetWrites == 0, "R6 no reset", resetWrites, 0);
  endtask

  task automatic testUnlockLimit();
    runSeq(1'b1, 1'b0, 1000000, 0, 0);
    chk(fail, "R6 unlock fail", fail, 1);
    chk(pulses == 1000, "R6 unlock budget", pulses, 1000);
  endtask

  task automatic testHold();
    repeat (25) @(negedge clk);
    chk(fail && !done, "R8 fail held", {done, fail}, 1);
    runSeq(1'b0, 1'b0, 1, 0, 0);
    chk(done && !fail, "R8 start clears fail", {done, fail}, 2);
    repeat (25) @(negedge clk);
    chk(done && !fail, "R8 done held", {done, fail}, 2);
  endtask

  task automatic testLowVolt();
    runSeq(1'b0, 1'b1, 2, 3, 0);
    chk(done, "R9 done", done, 1);
    chk(pulses == 2 && unlockWrites == 2, "R9 unlock per pulse", unlockWrites, 2);
    chk(maxW == 1 && minW == 1, "R9 strobe width", maxW, 1);
    chk(pulseHv == 0 && vfyHvBad == 0, "R9 no hv", pulseHv, 0);
    chk(reads == 12, "R10 poll reads", reads, 12);
  endtask

  task automatic testTick();
    tickDiv = 3;
    runSeq(1'b0, 1'b0, 1, 0, 0);
    chk(minW >= 28 && maxW <= 30, "R11 tick width", maxW, 29);
    tickDiv = 1;
  endtask

  task automatic testLatch();
    runSeq(1'b0, 1'b0, 2, 0, 5);
    chk(done && a6Ones == 0, "R13 mode latched", a6Ones, 0);
    chk(unlockWrites == 0 && pulseHv == 2, "R13 lowvolt latched", pulseHv, 2);
    modeUnprot = 1'b0; lowVolt = 1'b0;
  endtask

  initial begin
    prevWe = 1'b1; prevOe = 1'b1; weLow = 0;
    testReset();
    testLockPass();
    testUnlockPass();
    testLockLimit();
    testUnlockLimit();
    testHold();
    testLowVolt();
    testTick();
    testLatch();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule